// File: doc/BRIEF.md
# Pipeline hazard detection unit

This block is the hazard controller for a five-stage, in-order integer pipeline. The stages are fetch, decode, execute, memory and writeback, and branches are resolved in decode. The unit looks at three things: the register specifiers held in decode and execute, the destination specifiers of the execute, memory and writeback stages, and a few per-stage control bits (register write, load, branch, taken, jump). From these it produces operand bypass selects for the execute stage, bypass selects for the decode-stage branch comparator, hold enables for the fetch and decode registers, a bubble insert for the execute register, and a squash for the decode register.

The unit is purely combinational. Every output is a function of the inputs in the same cycle, so the unit adds no cycle of delay. The surrounding pipeline registers its outputs as part of its own stage registers. Register 0 is hard-wired to zero, so a match on it never selects a bypass path. Because branches resolve in decode, a taken branch or a jump loses exactly one fetch slot, and the squash output supplies that loss.

Top module: `hazard_unit`

## Requirements
- R1: The execute bypass select for operand A (`fwd_exe_a`) is 2'b10 (take memory-stage result) when `exe_src_a` is nonzero, equals `mem_dst`, and `mem_wr_en` is 1. This holds whatever the writeback stage holds.
- R2: When R1 does not apply, `fwd_exe_a` is 2'b01 (take writeback result) if `exe_src_a` is nonzero, equals `wb_dst`, and `wb_wr_en` is 1.
- R3: In every other case `fwd_exe_a` is 2'b00 (register-file value). This includes every case where `exe_src_a` is 0. The value 2'b11 never appears.
- R4: `fwd_exe_b` follows R1 to R3 with `exe_src_b` in place of `exe_src_a`. The two operands are independent of each other.
- R5: `fwd_dec_a` / `fwd_dec_b` are 1 exactly when `dec_src_a` / `dec_src_b` is nonzero, equals `mem_dst`, and `mem_wr_en` is 1. A writeback-stage match never sets them.
- R6: A load-use stall is raised when `exe_load` is 1 and `exe_src_b` equals `dec_src_a` or `dec_src_b`.
- R7: A branch stall is raised when `dec_branch` is 1, `exe_wr_en` is 1, and `exe_dst` equals `dec_src_a` or `dec_src_b`.
- R8: A branch stall is also raised when `dec_branch` is 1, `mem_load` is 1, and `mem_dst` equals `dec_src_a` or `dec_src_b`.
- R9: `hold_fetch`, `hold_decode` and `bubble_exe` are all equal to the OR of the load-use stall and the branch stall. A register match in execute with `dec_branch` at 0 and `exe_load` at 0 raises none of them.
- R10: `squash_decode` is 1 when (`dec_taken` and `dec_branch`) or `dec_jump` is 1 and no stall is raised. When a stall is raised it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_a | input | 5 | First source register of the decode-stage instruction |
| dec_src_b | input | 5 | Second source register of the decode-stage instruction |
| exe_src_a | input | 5 | First source register of the execute-stage instruction |
| exe_src_b | input | 5 | Second source register of the execute-stage instruction (also the load target) |
| exe_dst | input | 5 | Destination register of the execute-stage instruction |
| mem_dst | input | 5 | Destination register of the memory-stage instruction |
| wb_dst | input | 5 | Destination register of the writeback-stage instruction |
| exe_wr_en | input | 1 | Execute-stage instruction writes a register |
| exe_load | input | 1 | Execute-stage instruction is a load |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wb_wr_en | input | 1 | Writeback-stage instruction writes a register |
| dec_branch | input | 1 | Decode-stage instruction is a conditional branch |
| dec_taken | input | 1 | Decode-stage branch comparison resolved taken |
| dec_jump | input | 1 | Decode-stage instruction is an unconditional jump |
| fwd_exe_a | output | 2 | Execute operand A source: 10 memory, 01 writeback, 00 register file |
| fwd_exe_b | output | 2 | Execute operand B source, same encoding |
| fwd_dec_a | output | 1 | Branch comparator operand A takes the memory-stage result |
| fwd_dec_b | output | 1 | Branch comparator operand B takes the memory-stage result |
| hold_fetch | output | 1 | Hold the program counter / fetch register |
| hold_decode | output | 1 | Hold the decode register |
| bubble_exe | output | 1 | Clear the execute register (insert a bubble) |
| squash_decode | output | 1 | Clear the decode register (drop the wrongly fetched instruction) |

## Verification
The assertions assume that every input is a defined 0/1 value, and they check only while that holds. They also assume that the control bits are self-consistent the way a decoder would make them: a load also writes a register, and `dec_taken` only matters together with `dec_branch`. The stimulus keeps to this. Whenever a vector sets `exe_load` or `mem_load`, it also sets the matching write enable. The random vectors draw register numbers from a small range so that the specifier matches and the register-0 cases come up often. The directed vectors cover the memory-over-writeback priority, decode bypass from writeback only, and a stall coinciding with a taken branch.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

  // Execute-stage operand source encoding.
  typedef enum logic [1:0] {
    SRC_REGFILE = 2'b00,
    SRC_WB      = 2'b01,
    SRC_MEM     = 2'b10
  } exe_src_e;

  localparam int unsigned NUM_OPS = 2;

endpackage

// File: rtl/hz_exe_fwd.sv
module hz_exe_fwd
  import hazard_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wr_en,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wr_en,
  output exe_src_e         sel
);

  logic src_live;
  logic hit_mem;
  logic hit_wb;

  assign src_live = (src != '0);
  assign hit_mem  = src_live && mem_wr_en && (src == mem_dst);
  assign hit_wb   = src_live && wb_wr_en  && (src == wb_dst);

  // Newer producer (memory stage) wins over older (writeback).
  always_comb begin
    if (hit_mem)     sel = SRC_MEM;
    else if (hit_wb) sel = SRC_WB;
    else             sel = SRC_REGFILE;
  end

endmodule

// File: rtl/hz_dec_fwd.sv
module hz_dec_fwd #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wr_en,
  output logic             use_mem
);

  // Writeback results reach decode through the register file write-first
  // path, so only the memory stage needs a comparator bypass.
  assign use_mem = (src != '0) && mem_wr_en && (src == mem_dst);

endmodule

// File: rtl/hz_stall_ctl.sv
module hz_stall_ctl #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] dec_src_a,
  input  logic [REG_W-1:0] dec_src_b,
  input  logic [REG_W-1:0] exe_src_b,
  input  logic [REG_W-1:0] exe_dst,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             exe_wr_en,
  input  logic             exe_load,
  input  logic             mem_load,
  input  logic             dec_branch,
  input  logic             dec_taken,
  input  logic             dec_jump,
  output logic             stall,
  output logic             squash
);

  logic load_use;
  logic br_on_exe;
  logic br_on_mem;
  logic redirect;

  // Load result is not ready until after memory: consumer in decode waits.
  assign load_use  = exe_load &&
                     ((exe_src_b == dec_src_a) || (exe_src_b == dec_src_b));

  // Early branch compare needs operands one stage sooner.
  assign br_on_exe = dec_branch && exe_wr_en &&
                     ((exe_dst == dec_src_a) || (exe_dst == dec_src_b));
  assign br_on_mem = dec_branch && mem_load &&
                     ((mem_dst == dec_src_a) || (mem_dst == dec_src_b));

  assign stall    = load_use || br_on_exe || br_on_mem;
  assign redirect = (dec_branch && dec_taken) || dec_jump;

  // A stalled redirect is re-evaluated next cycle; do not kill it now.
  assign squash   = redirect && !stall;

endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hazard_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] dec_src_a,
  input  logic [REG_W-1:0] dec_src_b,
  input  logic [REG_W-1:0] exe_src_a,
  input  logic [REG_W-1:0] exe_src_b,
  input  logic [REG_W-1:0] exe_dst,
  input  logic [REG_W-1:0] mem_dst,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             exe_wr_en,
  input  logic             exe_load,
  input  logic             mem_wr_en,
  input  logic             mem_load,
  input  logic             wb_wr_en,
  input  logic             dec_branch,
  input  logic             dec_taken,
  input  logic             dec_jump,
  output logic [1:0]       fwd_exe_a,
  output logic [1:0]       fwd_exe_b,
  output logic             fwd_dec_a,
  output logic             fwd_dec_b,
  output logic             hold_fetch,
  output logic             hold_decode,
  output logic             bubble_exe,
  output logic             squash_decode
);

  logic [REG_W-1:0] exe_srcs [NUM_OPS];
  logic [REG_W-1:0] dec_srcs [NUM_OPS];
  exe_src_e         exe_sel  [NUM_OPS];
  logic             dec_sel  [NUM_OPS];
  logic             stall;

  assign exe_srcs[0] = exe_src_a;
  assign exe_srcs[1] = exe_src_b;
  assign dec_srcs[0] = dec_src_a;
  assign dec_srcs[1] = dec_src_b;

  for (genvar op = 0; op < NUM_OPS; op++) begin : g_op
    hz_exe_fwd #(.REG_W(REG_W)) u_exe (
      .src       (exe_srcs[op]),
      .mem_dst   (mem_dst),
      .mem_wr_en (mem_wr_en),
      .wb_dst    (wb_dst),
      .wb_wr_en  (wb_wr_en),
      .sel       (exe_sel[op])
    );
    hz_dec_fwd #(.REG_W(REG_W)) u_dec (
      .src       (dec_srcs[op]),
      .mem_dst   (mem_dst),
      .mem_wr_en (mem_wr_en),
      .use_mem   (dec_sel[op])
    );
  end

  hz_stall_ctl #(.REG_W(REG_W)) u_stall (
    .dec_src_a  (dec_src_a),
    .dec_src_b  (dec_src_b),
    .exe_src_b  (exe_src_b),
    .exe_dst    (exe_dst),
    .mem_dst    (mem_dst),
    .exe_wr_en  (exe_wr_en),
    .exe_load   (exe_load),
    .mem_load   (mem_load),
    .dec_branch (dec_branch),
    .dec_taken  (dec_taken),
    .dec_jump   (dec_jump),
    .stall      (stall),
    .squash     (squash_decode)
  );

  assign fwd_exe_a   = exe_sel[0];
  assign fwd_exe_b   = exe_sel[1];
  assign fwd_dec_a   = dec_sel[0];
  assign fwd_dec_b   = dec_sel[1];
  assign hold_fetch  = stall;
  assign hold_decode = stall;
  assign bubble_exe  = stall;

endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk #(
  parameter int unsigned REG_W = 5
) (
  input logic [REG_W-1:0] dec_src_a,
  input logic [REG_W-1:0] dec_src_b,
  input logic [REG_W-1:0] exe_src_a,
  input logic [REG_W-1:0] exe_src_b,
  input logic [REG_W-1:0] exe_dst,
  input logic [REG_W-1:0] mem_dst,
  input logic [REG_W-1:0] wb_dst,
  input logic             exe_wr_en,
  input logic             exe_load,
  input logic             mem_wr_en,
  input logic             mem_load,
  input logic             wb_wr_en,
  input logic             dec_branch,
  input logic             dec_taken,
  input logic             dec_jump,
  input logic [1:0]       fwd_exe_a,
  input logic [1:0]       fwd_exe_b,
  input logic             fwd_dec_a,
  input logic             fwd_dec_b,
  input logic             hold_fetch,
  input logic             hold_decode,
  input logic             bubble_exe,
  input logic             squash_decode
);

  logic known;

  always_comb begin
    known = !$isunknown({dec_src_a, dec_src_b, exe_src_a, exe_src_b, exe_dst,
                         mem_dst, wb_dst, exe_wr_en, exe_load, mem_wr_en,
                         mem_load, wb_wr_en, dec_branch, dec_taken, dec_jump,
                         fwd_exe_a, fwd_exe_b, fwd_dec_a, fwd_dec_b,
                         hold_fetch, hold_decode, bubble_exe, squash_decode});
    if (known) begin
      a_r1_mem_priority: assert (!((exe_src_a != '0) && mem_wr_en &&
                                   (exe_src_a == mem_dst)) || (fwd_exe_a == 2'b10))
        else $error("operand A ignored memory-stage match");
      a_r3_no_code_3: assert ((fwd_exe_a != 2'b11) && (fwd_exe_b != 2'b11))
        else $error("illegal execute bypass code");
      a_r3_zero_reg_a: assert ((exe_src_a != '0) || (fwd_exe_a == 2'b00))
        else $error("register 0 bypassed on operand A");
      a_r4_zero_reg_b: assert ((exe_src_b != '0) || (fwd_exe_b == 2'b00))
        else $error("register 0 bypassed on operand B");
      a_r5_dec_needs_mem: assert (!(fwd_dec_a || fwd_dec_b) || mem_wr_en)
        else $error("decode bypass without memory-stage write");
      a_r6_load_use: assert (!(exe_load && (exe_src_b == dec_src_a)) || hold_fetch)
        else $error("load-use hazard not stalled");
      a_r7_branch_exe: assert (!(dec_branch && exe_wr_en &&
                                 (exe_dst == dec_src_b)) || hold_decode)
        else $error("branch on execute result not stalled");
      a_r9_stall_agree: assert ((hold_fetch == hold_decode) && (hold_decode == bubble_exe))
        else $error("stall outputs disagree");
      a_r10_squash_yields: assert (!(squash_decode && hold_decode))
        else $error("squash asserted during stall");
    end
  end

endmodule

bind hazard_unit hazard_unit_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/hazard_unit_test.sv
`timescale 1ns/1ps
module hazard_unit_test;

  localparam int W = 5;

  typedef struct packed {
    logic [1:0] fa, fb;
    logic       da, db, stall, squash;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [W-1:0] dec_src_a, dec_src_b, exe_src_a, exe_src_b, exe_dst, mem_dst, wb_dst;
  logic exe_wr_en, exe_load, mem_wr_en, mem_load, wb_wr_en, dec_branch, dec_taken, dec_jump;
  logic [1:0] fwd_exe_a, fwd_exe_b;
  logic fwd_dec_a, fwd_dec_b, hold_fetch, hold_decode, bubble_exe, squash_decode;

  hazard_unit #(.REG_W(W)) uut (.*);

  exp_t exp_q[$];
  int   n_vec  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  function automatic logic [1:0] exe_ref(logic [W-1:0] s);
    if (s != 0 && mem_wr_en && s == mem_dst) return 2'b10;   // R1
    if (s != 0 && wb_wr_en && s == wb_dst)   return 2'b01;   // R2
    return 2'b00;                                            // R3
  endfunction

  task automatic drive(input logic [W-1:0] da, db, ea, eb, ed, md, wd,
                       input logic ew, el, mw, ml, ww, br, tk, jp);
    exp_t e;
    logic lu, bs;
    @(negedge clk);
    dec_src_a = da; dec_src_b = db; exe_src_a = ea; exe_src_b = eb;
    exe_dst = ed; mem_dst = md; wb_dst = wd;
    exe_wr_en = ew; exe_load = el; mem_wr_en = mw; mem_load = ml; wb_wr_en = ww;
    dec_branch = br; dec_taken = tk; dec_jump = jp;
    e.fa = exe_ref(ea);                                       // R4 same rule per operand
    e.fb = exe_ref(eb);
    e.da = (da != 0) && mw && (da == md);                     // R5
    e.db = (db != 0) && mw && (db == md);
    lu = el && (eb == da || eb == db);                        // R6
    bs = (br && ew && (ed == da || ed == db)) ||              // R7
         (br && ml && (md == da || md == db));                // R8
    e.stall  = lu || bs;                                      // R9
    e.squash = ((br && tk) || jp) && !e.stall;                // R10
    exp_q.push_back(e);
  endtask

  task automatic cmp(input string req, input logic [1:0] act, input logic [1:0] expv);
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s vector %0d: actual %b expected %b", req, n_vec, act, expv);
    end
  endtask

  // Monitor: compare at the rising edge, half a cycle after inputs change.
  initial begin
    forever begin
      @(posedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_vec++;
        cmp("R1/R2/R3 fwd_exe_a", fwd_exe_a, e.fa);
        cmp("R4 fwd_exe_b", fwd_exe_b, e.fb);
        cmp("R5 fwd_dec_a", {1'b0, fwd_dec_a}, {1'b0, e.da});
        cmp("R5 fwd_dec_b", {1'b0, fwd_dec_b}, {1'b0, e.db});
        cmp("R9 hold_fetch", {1'b0, hold_fetch}, {1'b0, e.stall});
        cmp("R9 hold_decode", {1'b0, hold_decode}, {1'b0, e.stall});
        cmp("R9 bubble_exe", {1'b0, bubble_exe}, {1'b0, e.stall});
        cmp("R10 squash_decode", {1'b0, squash_decode}, {1'b0, e.squash});
      end
    end
  end

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // quiet state: all outputs zero (reset-like idle)
    drive(0,0,0,0,0,0,0, 0,0,0,0,0, 0,0,0);
    // R1: memory beats writeback on same register
    drive(1,2,7,0,0,7,7, 0,0,1,0,1, 0,0,0);
    // R2: writeback only
    drive(1,2,9,9,0,3,9, 0,0,1,0,1, 0,0,0);
    // R3: register 0 never bypassed even with matches
    drive(0,0,0,0,0,0,0, 1,0,1,0,1, 0,0,0);
    // R3: match but write enable low
    drive(1,2,6,6,0,6,6, 0,0,0,0,0, 0,0,0);
    // R4: operands independent, A from mem, B from wb
    drive(1,2,4,5,0,4,5, 0,0,1,0,1, 0,0,0);
    // R5: decode bypass from memory; writeback match ignored
    drive(8,3,0,0,0,8,3, 0,0,1,0,1, 0,0,0);
    // R5: decode rt from mem, reg 0 in rs
    drive(0,11,0,0,0,11,0, 0,0,1,0,0, 0,0,0);
    // R6: load-use on rs and on rt
    drive(12,1,0,12,12,0,0, 1,1,0,0,0, 0,0,0);
    drive(1,13,0,13,13,0,0, 1,1,0,0,0, 0,0,0);
    // R7: branch depends on execute ALU result
    drive(14,2,0,0,14,0,0, 1,0,0,0,0, 1,1,0);
    // R8: branch depends on memory-stage load
    drive(3,15,0,0,0,15,0, 0,0,1,1,0, 1,0,0);
    // R8 negative: memory-stage non-load only bypasses
    drive(3,15,0,0,0,15,0, 0,0,1,0,0, 1,1,0);
    // R9: execute match without branch/load raises nothing
    drive(16,17,0,0,16,0,0, 1,0,0,0,0, 0,0,0);
    // R10: taken branch squashes; jump squashes; not-taken does not
    drive(1,2,0,0,0,0,0, 0,0,0,0,0, 1,1,0);
    drive(1,2,0,0,0,0,0, 0,0,0,0,0, 0,0,1);
    drive(1,2,0,0,0,0,0, 0,0,0,0,0, 1,0,0);
    // R10: stall suppresses squash (jump with load-use)
    drive(5,6,0,5,5,0,0, 1,1,0,0,0, 0,0,1);
    // random mix with small register range
    for (int i = 0; i < 400; i++) begin
      logic el, ml;
      el = $urandom_range(0,3) == 0;
      ml = $urandom_range(0,3) == 0;
      drive($urandom_range(0,3), $urandom_range(0,3), $urandom_range(0,3),
            $urandom_range(0,3), $urandom_range(0,3), $urandom_range(0,3),
            $urandom_range(0,3),
            el | ($urandom_range(0,1) == 1), el,
            ml | ($urandom_range(0,1) == 1), ml,
            $urandom_range(0,1) == 1,
            $urandom_range(0,1) == 1, $urandom_range(0,1) == 1,
            $urandom_range(0,5) == 0);
    end
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule